// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupts

This block holds eight 32-bit event counters behind a small register bus. Each counter has its own byte-wide event code. The code picks one of the external event inputs. A nonzero code lets the counter advance by one on every clock in which the picked input is high, provided the shared global enable is on. A code of zero parks the counter. Software can write any counter at any time.

The usual way to use a counter is to preload it with the negative of a period N. It then wraps to zero after exactly N events. The wrap sets a sticky overflow flag in the shared control word. Each counter drives its own interrupt line. That line is high while the counter's flag is set and its interrupt enable bit is set. Software clears a flag by writing a one to it.

The control word sits at byte offset 0x00. Bit 0 is the global enable. Bits 8 to 15 are the interrupt enables for counters 0 to 7. Bits 16 to 23 are the overflow flags for counters 0 to 7. The event codes are held in two words, at 0x04 and 0x08. Counter i is at 0x0C + 4*i. Reads are combinational from the current register state.

Top module: `evmon_bank`

## Requirements
- R1: After reset every counter, every event code, the control word and every interrupt line read as zero.
- R2: A write to offset 0x0C+4*i loads counter i, using only the byte lanes whose bus_be bit is set, and the new value reads back. A write to a counter takes precedence over an increment in the same cycle.
- R3: Counter i advances by exactly one on each clock in which all of these hold: control bit 0 is set, its event code c is in the range 1 to N_EVT, and evt_in[c-1] is high. A code above N_EVT never counts.
- R4: Counter i does not change while its event code is zero, whatever the event inputs do.
- R5: While control bit 0 is clear, no counter changes unless it is written.
- R6: When counter i advances from 0xFFFFFFFF to 0, control bit 16+i becomes set on the same clock edge. The bit stays set until software clears it.
- R7: Writing a control word with byte lane 2 enabled clears every flag bit 16+i written as one. Flag bits written as zero are left as they are. A wrap in the same cycle as a clear of the same flag leaves the flag set.
- R8: irq[i] is high exactly when control bit 16+i and control bit 8+i are both set.
- R9: A counter preloaded with the two's complement of N wraps, and sets its flag, on the Nth counted event and not before.
- R10: Control bits 1 to 7 and 24 to 31 read as zero. The event codes are packed so that byte lane j of word 0x04 holds the code of counter j, and byte lane j of word 0x08 holds the code of counter 4+j. Only the enabled byte lanes are written. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_in | input | N_EVT | Event inputs, sampled on every clock |
| irq | output | NUM_CNT | Per-counter interrupt lines |

## Verification
Directed sequences cover the following cases:
- the reset image;
- partial byte-lane writes and an unmapped offset;
- a preload of minus five, which separates wrapping on the fifth event from wrapping on the fourth or sixth;
- a clear that lands in the same cycle as a wrap, which shows whether set or clear wins;
- a counter write during an active event, which shows whether the write or the increment wins.

The zero-code and global-disable cases apply all event inputs high, so that any leakage into a counter shows up at once.

A long random phase then mixes event codes that are valid, zero and out of range with random event patterns. It also uses near-wrap preloads and random control words with partial byte enables. Every read is compared each cycle with a model of the requirements. That comparison reveals errors in the input selection, the sticky flag and the interrupt gating that the directed cases could miss.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int WORD_W       = 32;
  localparam int CODE_W       = 8;
  localparam int OFF_CTRL     = 0;
  localparam int OFF_SEL      = 4;
  localparam int OFF_CNT      = 12;
  localparam int CTRL_IE_LSB  = 8;
  localparam int CTRL_OVF_LSB = 16;

  // byte offset of the word holding counter i's event code
  function automatic int sel_word_off(input int i);
    return OFF_SEL + 4 * (i / 4);
  endfunction

  // byte lane of counter i's event code inside that word
  function automatic int sel_lane(input int i);
    return i % 4;
  endfunction

  // byte offset of counter i's count register
  function automatic int cnt_off(input int i);
    return OFF_CNT + 4 * i;
  endfunction

  // replace only the enabled byte lanes of old_v by new_v
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_v,
                                                  input logic [WORD_W-1:0] new_v,
                                                  input logic [3:0]        be);
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction

  // true when one more increment wraps the value to zero
  function automatic logic at_wrap(input logic [WORD_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter
  import evmon_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [N_EVT-1:0]  ev,
  input  logic              sel_we,
  input  logic [CODE_W-1:0] sel_d,
  input  logic              cnt_we,
  input  logic [WORD_W-1:0] cnt_d,
  input  logic [3:0]        cnt_be,
  output logic [CODE_W-1:0] code,
  output logic [WORD_W-1:0] count,
  output logic              wrap
);
  // level of the event input that code c selects; codes 0 and above N_EVT select nothing
  function automatic logic pick_event(input logic [CODE_W-1:0] c, input logic [N_EVT-1:0] e);
    logic r;
    r = 1'b0;
    for (int k = 0; k < N_EVT; k++)
      if (c == CODE_W'(k + 1)) r = e[k];
    return r;
  endfunction

  logic bump;

  assign bump = run && (code != '0) && pick_event(code, ev);
  assign wrap = bump && !cnt_we && at_wrap(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code <= '0;
    else if (sel_we) code <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_we) count <= lane_merge(count, cnt_d, cnt_be);
    else if (bump)   count <= count + WORD_W'(1);
  end
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gen_we,
  input  logic               gen_d,
  input  logic               ie_we,
  input  logic [NUM_CNT-1:0] ie_d,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_d,
  input  logic [NUM_CNT-1:0] wrap,
  output logic               gen_en,
  output logic [NUM_CNT-1:0] ie,
  output logic [NUM_CNT-1:0] flag,
  output logic [WORD_W-1:0]  ctrl_word,
  output logic [NUM_CNT-1:0] irq
);
  logic [NUM_CNT-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_d : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      ie     <= '0;
      flag   <= '0;
    end else begin
      if (gen_we) gen_en <= gen_d;
      if (ie_we)  ie     <= ie_d;
      flag <= (flag & ~clr_mask) | wrap;  // set wins over clear
    end
  end

  always_comb begin
    ctrl_word    = '0;
    ctrl_word[0] = gen_en;
    for (int i = 0; i < NUM_CNT; i++) begin
      ctrl_word[CTRL_IE_LSB + i]  = ie[i];
      ctrl_word[CTRL_OVF_LSB + i] = flag[i];
    end
  end

  assign irq = flag & ie;
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank
  import evmon_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int N_EVT   = 8,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [3:0]         bus_be,
  output logic [31:0]        bus_rdata,
  input  logic [N_EVT-1:0]   evt_in,
  output logic [NUM_CNT-1:0] irq
);
  logic                            ctl_wr;
  logic                            gen_en;
  logic [NUM_CNT-1:0]              ie;
  logic [NUM_CNT-1:0]              flag;
  logic [NUM_CNT-1:0]              wrap;
  logic [NUM_CNT-1:0]              cnt_wr;
  logic [NUM_CNT-1:0]              sel_wr;
  logic [NUM_CNT-1:0][WORD_W-1:0]  counts;
  logic [NUM_CNT-1:0][CODE_W-1:0]  codes;
  logic [WORD_W-1:0]               ctrl_word;

  assign ctl_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int LANE = sel_lane(i);
    assign cnt_wr[i] = bus_we && (bus_addr == ADDR_W'(cnt_off(i)));
    assign sel_wr[i] = bus_we && (bus_addr == ADDR_W'(sel_word_off(i))) && bus_be[LANE];

    evmon_counter #(.N_EVT(N_EVT)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (gen_en),
      .ev     (evt_in),
      .sel_we (sel_wr[i]),
      .sel_d  (bus_wdata[8*LANE +: 8]),
      .cnt_we (cnt_wr[i]),
      .cnt_d  (bus_wdata),
      .cnt_be (bus_be),
      .code   (codes[i]),
      .count  (counts[i]),
      .wrap   (wrap[i])
    );
  end

  evmon_ctrl #(.NUM_CNT(NUM_CNT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_we    (ctl_wr && bus_be[0]),
    .gen_d     (bus_wdata[0]),
    .ie_we     (ctl_wr && bus_be[1]),
    .ie_d      (bus_wdata[CTRL_IE_LSB +: NUM_CNT]),
    .clr_we    (ctl_wr && bus_be[2]),
    .clr_d     (bus_wdata[CTRL_OVF_LSB +: NUM_CNT]),
    .wrap      (wrap),
    .gen_en    (gen_en),
    .ie        (ie),
    .flag      (flag),
    .ctrl_word (ctrl_word),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_word;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(sel_word_off(i)))
        bus_rdata[8*sel_lane(i) +: 8] = codes[i];
      if (bus_addr == ADDR_W'(cnt_off(i)))
        bus_rdata = counts[i];
    end
  end
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
  parameter int NUM_CNT = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctl_wr,
  input logic [31:0]                bus_wdata,
  input logic [3:0]                 bus_be,
  input logic                       gen_en,
  input logic [NUM_CNT-1:0]         ie,
  input logic [NUM_CNT-1:0]         flag,
  input logic [NUM_CNT-1:0]         wrap,
  input logic [NUM_CNT-1:0]         cnt_wr,
  input logic [NUM_CNT-1:0]         irq,
  input logic [NUM_CNT-1:0][31:0]   counts,
  input logic [NUM_CNT-1:0][7:0]    codes
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    logic clr_hit;
    assign clr_hit = ctl_wr && bus_be[2] && bus_wdata[16+i];

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr[i] |=> (counts[i] == $past(counts[i]) || counts[i] == $past(counts[i]) + 32'd1)); // R3
    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (codes[i] == 8'd0) && !cnt_wr[i] |=> $stable(counts[i])); // R4
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en && !cnt_wr[i] |=> $stable(counts[i])); // R5
    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[i] |=> flag[i] && (counts[i] == 32'd0)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag[i] && !clr_hit |=> flag[i]); // R6
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit && !wrap[i] |=> !flag[i]); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i] && ie[i]); // R8
  end
endmodule

bind evmon_bank evmon_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be),
  .gen_en    (gen_en),
  .ie        (ie),
  .flag      (flag),
  .wrap      (wrap),
  .cnt_wr    (cnt_wr),
  .irq       (irq),
  .counts    (counts),
  .codes     (codes)
);

// File: tb/tb_evmon_bank.sv
`timescale 1ns/1ps
module tb_evmon_bank;
  localparam int NC = 8;
  localparam int NE = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_rdata;
  logic [NE-1:0] evt_in = '0;
  logic [NC-1:0] irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_cnt [NC];
  logic [7:0]  m_code [NC];
  logic        m_gen;
  logic [7:0]  m_ie;
  logic [7:0]  m_flag;
  logic [31:0] last_rd;

  always #4 clk = ~clk;

  evmon_bank #(.NUM_CNT(NC), .N_EVT(NE), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq(irq)
  );

  function automatic logic [31:0] merge_bytes(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] be);
    logic [31:0] r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int ai = int'(a);
    if (ai == 0) return {8'h00, m_flag, m_ie, 7'h00, m_gen};
    if (ai == 4) return {m_code[3], m_code[2], m_code[1], m_code[0]};
    if (ai == 8) return {m_code[7], m_code[6], m_code[5], m_code[4]};
    if (ai >= 12 && ai <= 12 + 4*(NC-1) && (ai % 4) == 0) return m_cnt[(ai-12)/4];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    int ai = int'(a);
    if (ai == 0) return "R7";
    if (ai >= 12 && ai <= 12 + 4*(NC-1) && (ai % 4) == 0) return "R3";
    return "R10";
  endfunction

  function automatic logic counts_now(input int i, input logic [NE-1:0] ev);
    int c = int'(m_code[i]);
    if (!m_gen || c == 0 || c > NE) return 1'b0;
    return ev[c-1];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: compare the read of address a, then apply the stimulus to the model
  task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [NE-1:0] ev);
    logic [7:0] wrapv;
    logic [7:0] clr;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be; evt_in = ev;
    #1;
    last_rd = bus_rdata;
    check(bus_rdata, exp_read(a), tag_of(a));
    check({24'h0, irq}, {24'h0, m_flag & m_ie}, "R8");
    wrapv = '0;
    for (int i = 0; i < NC; i++) begin
      logic cw;
      logic hit;
      cw  = we && (int'(a) == 12 + 4*i);
      hit = counts_now(i, ev);
      if (cw) m_cnt[i] = merge_bytes(m_cnt[i], d, be);
      else if (hit) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrapv[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 32'd1;
      end
    end
    if (we && (a == 6'd4 || a == 6'd8)) begin
      for (int j = 0; j < 4; j++)
        if (be[j]) m_code[(a == 6'd8 ? 4 : 0) + j] = d[8*j +: 8];
    end
    clr = '0;
    if (we && a == 6'd0) begin
      if (be[0]) m_gen = d[0];
      if (be[1]) m_ie = d[15:8];
      if (be[2]) clr = d[23:16];
    end
    m_flag = (m_flag & ~clr) | wrapv;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, a, 32'h0, 4'h0, '0);
    check(last_rd, exp, tag);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_cnt[i] = '0; m_code[i] = '0; end
    m_gen = 0; m_ie = '0; m_flag = '0;
    void'($urandom(32'd1357));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset image
    expect_rd(6'h00, 32'h0, "R1");
    expect_rd(6'h04, 32'h0, "R1");
    expect_rd(6'h08, 32'h0, "R1");
    for (int i = 0; i < NC; i++) expect_rd(AW'(12 + 4*i), 32'h0, "R1");
    check({24'h0, irq}, 32'h0, "R1");

    // R10 reserved control bits, byte lanes, unmapped offset
    step(1'b1, 6'h00, 32'hFFFF_FFFF, 4'hF, '0);
    expect_rd(6'h00, 32'h0000_FF01, "R10");
    step(1'b1, 6'h00, 32'h0, 4'hF, '0);
    step(1'b1, 6'h04, 32'h4433_2211, 4'b0101, '0);
    expect_rd(6'h04, 32'h0033_0011, "R10");
    expect_rd(6'h30, 32'h0, "R10");

    // R2 load and read back
    step(1'b1, 6'h10, 32'h1234_5678, 4'hF, '0);
    expect_rd(6'h10, 32'h1234_5678, "R2");

    // R9 preload minus five on counter 0, code 1 -> evt_in[0]
    step(1'b1, 6'h04, 32'h0000_0001, 4'hF, '0);
    step(1'b1, 6'h0C, 32'hFFFF_FFFB, 4'hF, '0);
    step(1'b1, 6'h00, 32'h0000_0101, 4'hF, '0);
    repeat (4) step(1'b0, 6'h00, 32'h0, 4'h0, 8'h01);
    expect_rd(6'h0C, 32'hFFFF_FFFF, "R9");
    expect_rd(6'h00, 32'h0000_0101, "R9");
    step(1'b0, 6'h00, 32'h0, 4'h0, 8'h01);
    expect_rd(6'h0C, 32'h0, "R9");
    expect_rd(6'h00, 32'h0001_0101, "R6");
    check({24'h0, irq}, 32'h1, "R8");

    // R7 write zero keeps, write one clears, set wins over clear
    step(1'b1, 6'h00, 32'h0000_0101, 4'hF, '0);
    expect_rd(6'h00, 32'h0001_0101, "R7");
    step(1'b1, 6'h00, 32'h0001_0101, 4'hF, '0);
    expect_rd(6'h00, 32'h0000_0101, "R7");
    step(1'b1, 6'h0C, 32'hFFFF_FFFF, 4'hF, '0);
    step(1'b1, 6'h00, 32'h0001_0101, 4'hF, 8'h01);
    expect_rd(6'h00, 32'h0001_0101, "R7");
    expect_rd(6'h0C, 32'h0, "R6");

    // R2 write beats a same-cycle increment
    step(1'b1, 6'h0C, 32'h0000_0100, 4'hF, 8'h01);
    expect_rd(6'h0C, 32'h0000_0100, "R2");

    // R4 code zero parks the counter
    step(1'b1, 6'h04, 32'h0, 4'b0001, '0);
    repeat (3) step(1'b0, 6'h00, 32'h0, 4'h0, 8'hFF);
    expect_rd(6'h0C, 32'h0000_0100, "R4");

    // R5 global enable off stops counting, then R3 resumes
    step(1'b1, 6'h04, 32'h0000_0001, 4'b0001, '0);
    step(1'b1, 6'h00, 32'h0000_0100, 4'hF, '0);
    repeat (3) step(1'b0, 6'h00, 32'h0, 4'h0, 8'hFF);
    expect_rd(6'h0C, 32'h0000_0100, "R5");
    step(1'b1, 6'h00, 32'h0000_0101, 4'hF, '0);
    repeat (2) step(1'b0, 6'h00, 32'h0, 4'h0, 8'hFF);
    expect_rd(6'h0C, 32'h0000_0102, "R3");

    // random phase checked against the model
    for (int n = 0; n < 5000; n++) begin
      logic          we;
      logic [AW-1:0] a;
      logic [31:0]   d;
      logic [3:0]    be;
      int            pick;
      we   = ($urandom_range(3) == 0);
      pick = $urandom_range(11);
      a    = (pick < 10) ? AW'(4*pick) : 6'h2C;
      d    = $urandom();
      be   = ($urandom_range(3) == 0) ? 4'($urandom_range(15)) : 4'hF;
      if (int'(a) >= 12 && $urandom_range(1) == 0) d = 32'hFFFF_FFF0 | 32'($urandom_range(15));
      if (a == 6'h04 || a == 6'h08) begin
        for (int j = 0; j < 4; j++) d[8*j +: 8] = 8'($urandom_range(NE + 3));
      end
      if (a == 6'h00 && $urandom_range(3) != 0) d[0] = 1'b1;
      step(we, a, d, be, NE'($urandom()));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule